// File: doc/BRIEF.md
# Reset Sequencer with Cause Flags

This block brings a small processor core out of reset in a controlled order and keeps a set of sticky flags that tell software why the last reset or wake-up took place. It watches power-on and brown-out pulses, an active-low external reset pin, a watchdog time-out pulse, and an interrupt wake pulse. A sleep level from the core qualifies the watchdog and interrupt inputs.

After a power-on or brown-out pulse, the block can first run a power-up delay, which is counted in ticks of a slow time base. The delay runs only when its configuration bit is 0. A crystal oscillator mode then adds a fixed count of oscillator cycles so that the crystal can settle. An RC or internal oscillator mode adds a short core start-up count instead. A wake-up from sleep and a watchdog reset skip the power-up delay. The external pin is synchronised and holds the core in reset for as long as it is low. Once every delay has run out, releasing the pin frees the core straight away.

Four flags record the cause: time-out, power-down, power-on and brown-out. Software sets the power-on and brown-out flags through set strobes, so that the next reset can be told apart.

Top module: `rstseq_top`

## Requirements
- R1: While `rst_n` is low, the block enters the power-on state. On the first cycle after release, `core_rst`=1, `startup_done`=0, `flag_to`=1, `flag_pd`=1 and `flag_pon`=0.
- R2: Take a crystal mode (`cfg_osc_mode` 0, 1 or 2) with `cfg_pu_n`=0. After a `por_evt`, the sequence counts `PU_TICKS` cycles in which `slow_tick` is high, and then `OSC_CYCLES` clock cycles. `startup_done` rises at the end of the last count.
- R3: In a crystal mode with `cfg_pu_n`=1, a `por_evt` is followed only by the `OSC_CYCLES` count.
- R4: In a non-crystal mode (`cfg_osc_mode` 3 to 7), the power-up delay (when enabled) is followed by `CPU_CYCLES` clock cycles instead of the oscillator count.
- R5: A `bor_evt` runs the same chain as power-on. It sets `flag_to`=1 and `flag_pd`=1, clears `flag_bor` to 0, and leaves `flag_pon` unchanged.
- R6: The following three events skip the power-up delay:
  - a `wdt_evt` while `sleeping`=1;
  - a `wake_int` while `sleeping`=1;
  - a `wdt_evt` while `sleeping`=0.

  Each then waits `OSC_CYCLES` in crystal modes and `CPU_CYCLES` otherwise. A `wake_int` with `sleeping`=0 has no effect.
- R7: The time-out and power-down flags take these values:
  - watchdog reset while running: `flag_to`=0, `flag_pd`=1;
  - watchdog wake from sleep: both 0;
  - interrupt wake: `flag_to`=1, `flag_pd`=0.
- R8: A falling edge of `ext_rst_n` while not sleeping leaves all flags unchanged. `core_rst` goes high at most two cycles after the pin falls.
- R9: A falling edge of `ext_rst_n` while `sleeping`=1 sets `flag_to`=1 and `flag_pd`=0.
- R10: `core_rst` is high whenever the sequence is running or the synchronised pin is low. If the pin is still low after `startup_done` rises, `core_rst` falls on the second clock edge after the pin is raised, with no further delay.
- R11: `flag_pon` is cleared by a power-on event and changed otherwise only by `sw_set_pon`, which sets it. `sw_set_bor` sets `flag_bor`.
- R12: A `por_evt` or `bor_evt` that arrives while the sequence runs restarts it from the beginning.
- R13: When events arrive in the same cycle, the priority is power-on, then brown-out, then watchdog, then interrupt wake, then the external pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low register reset, treated as power-on |
| slow_tick | input | 1 | One-cycle enable from the slow time base |
| por_evt | input | 1 | Power-on event pulse |
| bor_evt | input | 1 | Brown-out event pulse |
| wdt_evt | input | 1 | Watchdog time-out pulse |
| wake_int | input | 1 | Interrupt wake pulse |
| sleeping | input | 1 | Core is in sleep |
| ext_rst_n | input | 1 | Asynchronous active-low external reset pin |
| cfg_pu_n | input | 1 | 0 enables the power-up delay |
| cfg_osc_mode | input | 3 | 0 to 2 crystal modes, 3 RC, 4 to 7 internal |
| sw_set_pon | input | 1 | Software strobe setting the power-on flag |
| sw_set_bor | input | 1 | Software strobe setting the brown-out flag |
| core_rst | output | 1 | Holds the core in reset |
| startup_done | output | 1 | Start-up sequence complete |
| flag_to | output | 1 | Time-out flag |
| flag_pd | output | 1 | Power-down flag |
| flag_pon | output | 1 | Power-on flag, 0 after power-on |
| flag_bor | output | 1 | Brown-out flag, 0 after brown-out |

## Verification
The bench builds the block with `PU_TICKS`=3, `OSC_CYCLES`=16 and `CPU_CYCLES`=4, and drives a slow tick every fifth cycle. With these values, each start-up finishes within a few dozen cycles. The bench can therefore sweep every oscillator mode code, both delay settings and every event kind, and it checks each sequence length against a count computed from the ticks it drove. The short counts also leave room for directed runs of restart, priority, pin hold and flag persistence.

// File: rtl/rstseq_pkg.sv
`timescale 1ns/1ps
// Shared types for the reset sequencer.
// Assumes oscillator modes 0..2 are crystal modes and every other code has no crystal.
package rstseq_pkg;

    localparam int MODE_W = 3;

    // Phase of the start-up sequence.
    typedef enum logic [1:0] {
        PH_DONE = 2'd0,
        PH_PU   = 2'd1,
        PH_OSC  = 2'd2,
        PH_CPU  = 2'd3
    } phase_t;

    // Classified cause, already resolved by priority.
    typedef enum logic [2:0] {
        EV_NONE      = 3'd0,
        EV_POR       = 3'd1,
        EV_BOR       = 3'd2,
        EV_WDT_RST   = 3'd3,
        EV_WDT_WAKE  = 3'd4,
        EV_INT_WAKE  = 3'd5,
        EV_EXT_RUN   = 3'd6,
        EV_EXT_SLEEP = 3'd7
    } cause_t;

    // True for the crystal oscillator modes.
    function automatic logic mode_is_crystal(input logic [MODE_W-1:0] m);
        return m < MODE_W'(3);
    endfunction

    // Causes that run the whole chain, power-up delay included.
    function automatic logic cause_full(input cause_t c);
        return (c == EV_POR) || (c == EV_BOR);
    endfunction

    // Causes that skip the power-up delay.
    function automatic logic cause_short(input cause_t c);
        return (c == EV_WDT_RST) || (c == EV_WDT_WAKE) || (c == EV_INT_WAKE);
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
`timescale 1ns/1ps
// Multi-flop synchroniser for one asynchronous level.
// Assumes the input is a slow level; STAGES >= 1; RST_VAL is the inactive level.
module rstseq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= d;
            end
        end else begin : g_chain
            // Shift the level through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/rstseq_decode.sv
`timescale 1ns/1ps
// Turns the raw event inputs into one prioritised cause per cycle.
// Assumes the event pulses are synchronous to clk and ext_level is already synchronised.
module rstseq_decode
    import rstseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   por_evt,
    input  logic   bor_evt,
    input  logic   wdt_evt,
    input  logic   wake_int,
    input  logic   sleeping,
    input  logic   ext_level,
    output cause_t cause
);

    logic ext_prev;
    logic ext_fall;

    // Remember the synchronised pin level for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_prev <= 1'b1;
        else        ext_prev <= ext_level;
    end

    assign ext_fall = ext_prev & ~ext_level;

    // Resolve simultaneous events: power-on, brown-out, watchdog, interrupt, pin.
    always_comb begin
        if (por_evt)                  cause = EV_POR;
        else if (bor_evt)             cause = EV_BOR;
        else if (wdt_evt && sleeping) cause = EV_WDT_WAKE;
        else if (wdt_evt)             cause = EV_WDT_RST;
        else if (wake_int && sleeping) cause = EV_INT_WAKE;
        else if (ext_fall && sleeping) cause = EV_EXT_SLEEP;
        else if (ext_fall)            cause = EV_EXT_RUN;
        else                          cause = EV_NONE;
    end

endmodule

// File: rtl/rstseq_flags.sv
`timescale 1ns/1ps
// Sticky cause flags, updated by the resolved cause and the software set strobes.
// Assumes the cause input already carries the priority. A cause wins over a
// strobe in the same cycle. The brown-out flag after power-on is left as it was (value undefined).
module rstseq_flags
    import rstseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  cause_t cause,
    input  logic   sw_set_pon,
    input  logic   sw_set_bor,
    output logic   flag_to,
    output logic   flag_pd,
    output logic   flag_pon,
    output logic   flag_bor
);

    // Time-out and power-down pair, driven by each cause pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_to <= 1'b1;
            flag_pd <= 1'b1;
        end else begin
            case (cause)
                EV_POR, EV_BOR: begin
                    flag_to <= 1'b1;
                    flag_pd <= 1'b1;
                end
                EV_WDT_RST: begin
                    flag_to <= 1'b0;
                    flag_pd <= 1'b1;
                end
                EV_WDT_WAKE: begin
                    flag_to <= 1'b0;
                    flag_pd <= 1'b0;
                end
                EV_INT_WAKE, EV_EXT_SLEEP: begin
                    flag_to <= 1'b1;
                    flag_pd <= 1'b0;
                end
                default: begin
                    flag_to <= flag_to;
                    flag_pd <= flag_pd;
                end
            endcase
        end
    end

    // Power-on flag: cleared by power-on, set by software.
    always_ff @(posedge clk) begin
        if (!rst_n)                 flag_pon <= 1'b0;
        else if (cause == EV_POR)   flag_pon <= 1'b0;
        else if (sw_set_pon)        flag_pon <= 1'b1;
    end

    // Brown-out flag: cleared by brown-out, set by software.
    always_ff @(posedge clk) begin
        if (!rst_n)                 flag_bor <= 1'b0;
        else if (cause == EV_BOR)   flag_bor <= 1'b0;
        else if (sw_set_bor)        flag_bor <= 1'b1;
    end

endmodule

// File: rtl/rstseq_fsm.sv
`timescale 1ns/1ps
// Start-up phase sequencer with one counter shared by every phase.
// Assumes all three length parameters are >= 1 and that a register reset
// acts as a power-on. Configuration is read live as each phase begins.
module rstseq_fsm
    import rstseq_pkg::*;
#(
    parameter int PU_TICKS   = 72,
    parameter int OSC_CYCLES = 1024,
    parameter int CPU_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              cfg_pu_n,
    input  logic [MODE_W-1:0] cfg_osc_mode,
    input  cause_t            cause,
    output logic              done
);

    localparam int MAX_A = (PU_TICKS > OSC_CYCLES) ? PU_TICKS : OSC_CYCLES;
    localparam int MAX_N = (MAX_A > CPU_CYCLES) ? MAX_A : CPU_CYCLES;
    localparam int CW    = $clog2(MAX_N + 1);

    phase_t        phase;
    phase_t        first_full;
    phase_t        first_short;
    phase_t        next_phase;
    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;
    logic          step;
    logic          xtal;

    assign xtal = mode_is_crystal(cfg_osc_mode);

    // Pick the entry phase of each path and the successor of the current phase.
    always_comb begin
        first_short = xtal ? PH_OSC : PH_CPU;
        first_full  = cfg_pu_n ? first_short : PH_PU;
        next_phase  = (phase == PH_PU) ? first_short : PH_DONE;
    end

    // Select the end count and the advance condition for the current phase.
    always_comb begin
        case (phase)
            PH_PU:   limit = CW'(PU_TICKS - 1);
            PH_OSC:  limit = CW'(OSC_CYCLES - 1);
            PH_CPU:  limit = CW'(CPU_CYCLES - 1);
            default: limit = '0;
        endcase
        step = (phase == PH_PU) ? slow_tick : (phase != PH_DONE);
    end

    // Phase register and shared counter; new full or short causes restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= first_full;
            cnt   <= '0;
        end else if (cause_full(cause)) begin
            phase <= first_full;
            cnt   <= '0;
        end else if (cause_short(cause)) begin
            phase <= first_short;
            cnt   <= '0;
        end else if (step) begin
            if (cnt == limit) begin
                phase <= next_phase;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign done = (phase == PH_DONE);

endmodule

// File: rtl/rstseq_top.sv
`timescale 1ns/1ps
// Reset sequencer top: synchronises the external pin, classifies causes,
// keeps the cause flags and runs the start-up phases.
// Assumes event pulses are synchronous to clk; only ext_rst_n is asynchronous.
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int PU_TICKS    = 72,
    parameter int OSC_CYCLES  = 1024,
    parameter int CPU_CYCLES  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              por_evt,
    input  logic              bor_evt,
    input  logic              wdt_evt,
    input  logic              wake_int,
    input  logic              sleeping,
    input  logic              ext_rst_n,
    input  logic              cfg_pu_n,
    input  logic [MODE_W-1:0] cfg_osc_mode,
    input  logic              sw_set_pon,
    input  logic              sw_set_bor,
    output logic              core_rst,
    output logic              startup_done,
    output logic              flag_to,
    output logic              flag_pd,
    output logic              flag_pon,
    output logic              flag_bor
);

    logic   ext_level;
    cause_t cause;
    logic   seq_done;

    rstseq_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ext_rst_n),
        .q     (ext_level)
    );

    rstseq_decode u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .por_evt   (por_evt),
        .bor_evt   (bor_evt),
        .wdt_evt   (wdt_evt),
        .wake_int  (wake_int),
        .sleeping  (sleeping),
        .ext_level (ext_level),
        .cause     (cause)
    );

    rstseq_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .cause      (cause),
        .sw_set_pon (sw_set_pon),
        .sw_set_bor (sw_set_bor),
        .flag_to    (flag_to),
        .flag_pd    (flag_pd),
        .flag_pon   (flag_pon),
        .flag_bor   (flag_bor)
    );

    rstseq_fsm #(
        .PU_TICKS   (PU_TICKS),
        .OSC_CYCLES (OSC_CYCLES),
        .CPU_CYCLES (CPU_CYCLES)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .slow_tick    (slow_tick),
        .cfg_pu_n     (cfg_pu_n),
        .cfg_osc_mode (cfg_osc_mode),
        .cause        (cause),
        .done         (seq_done)
    );

    // Core held while the sequence runs or the synchronised pin is low.
    assign core_rst     = ~seq_done | ~ext_level;
    assign startup_done = seq_done;

endmodule

// File: rtl/rstseq_chk.sv
`timescale 1ns/1ps
// Property checker for rstseq_top, attached by bind; observes ports only.
module rstseq_chk (
    input logic clk,
    input logic rst_n,
    input logic por_evt,
    input logic bor_evt,
    input logic wdt_evt,
    input logic wake_int,
    input logic sleeping,
    input logic sw_set_pon,
    input logic core_rst,
    input logic startup_done,
    input logic flag_to,
    input logic flag_pd,
    input logic flag_pon,
    input logic flag_bor
);

    // R10: core held whenever the sequence has not finished.
    assert_held_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !startup_done |-> core_rst);

    // R11: power-on clears its flag.
    assert_por_clears_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        por_evt |=> !flag_pon);

    // R11: power-on flag moves only on power-on or software set.
    assert_pon_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!por_evt && !sw_set_pon) |=> $stable(flag_pon));

    // R5: brown-out flag pattern.
    assert_bor_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bor_evt && !por_evt) |=> (flag_to && flag_pd && !flag_bor));

    // R7: watchdog reset while running.
    assert_wdt_run_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_evt && !sleeping && !por_evt && !bor_evt) |=> (!flag_to && flag_pd));

    // R12: a power-on or brown-out event always restarts the sequence.
    assert_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (por_evt || bor_evt) |=> !startup_done);

    // R6: a finished sequence stays finished without a sequencing event.
    assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (startup_done && !por_evt && !bor_evt && !wdt_evt && !(wake_int && sleeping))
        |=> startup_done);

endmodule

bind rstseq_top rstseq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .por_evt      (por_evt),
    .bor_evt      (bor_evt),
    .wdt_evt      (wdt_evt),
    .wake_int     (wake_int),
    .sleeping     (sleeping),
    .sw_set_pon   (sw_set_pon),
    .core_rst     (core_rst),
    .startup_done (startup_done),
    .flag_to      (flag_to),
    .flag_pd      (flag_pd),
    .flag_pon     (flag_pon),
    .flag_bor     (flag_bor)
);

// File: tb/rstseq_top_tb.sv
`timescale 1ns/1ps
// Sweep bench for rstseq_top with short delay parameters.
module rstseq_top_tb;

    localparam int P    = 3;
    localparam int O    = 16;
    localparam int C    = 4;
    localparam int TDIV = 5;

    localparam int K_POR     = 0;
    localparam int K_BOR     = 1;
    localparam int K_WDT_RUN = 2;
    localparam int K_WDT_SLP = 3;
    localparam int K_INT     = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_tick = 1'b0;
    logic       por_evt = 1'b0;
    logic       bor_evt = 1'b0;
    logic       wdt_evt = 1'b0;
    logic       wake_int = 1'b0;
    logic       sleeping = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic       cfg_pu_n = 1'b0;
    logic [2:0] cfg_osc_mode = 3'd0;
    logic       sw_set_pon = 1'b0;
    logic       sw_set_bor = 1'b0;
    logic       core_rst, startup_done, flag_to, flag_pd, flag_pon, flag_bor;

    int errors = 0;
    int checks = 0;
    int tdiv_cnt = 0;

    rstseq_top #(
        .PU_TICKS   (P),
        .OSC_CYCLES (O),
        .CPU_CYCLES (C)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .slow_tick    (slow_tick),
        .por_evt      (por_evt),
        .bor_evt      (bor_evt),
        .wdt_evt      (wdt_evt),
        .wake_int     (wake_int),
        .sleeping     (sleeping),
        .ext_rst_n    (ext_rst_n),
        .cfg_pu_n     (cfg_pu_n),
        .cfg_osc_mode (cfg_osc_mode),
        .sw_set_pon   (sw_set_pon),
        .sw_set_bor   (sw_set_bor),
        .core_rst     (core_rst),
        .startup_done (startup_done),
        .flag_to      (flag_to),
        .flag_pd      (flag_pd),
        .flag_pon     (flag_pon),
        .flag_bor     (flag_bor)
    );

    always #2 clk = ~clk;

    // Slow time base: one tick every TDIV cycles, driven away from the active edge.
    always @(negedge clk) begin
        tdiv_cnt  = (tdiv_cnt == TDIV - 1) ? 0 : tdiv_cnt + 1;
        slow_tick = (tdiv_cnt == 0);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // Drive one event for one cycle; returns at the negedge after the sampling edge.
    task automatic fire(input int kind);
        @(negedge clk);
        case (kind)
            K_POR:     por_evt = 1'b1;
            K_BOR:     bor_evt = 1'b1;
            K_WDT_RUN: wdt_evt = 1'b1;
            K_WDT_SLP: begin wdt_evt = 1'b1; sleeping = 1'b1; end
            default:   begin wake_int = 1'b1; sleeping = 1'b1; end
        endcase
        @(posedge clk);
        @(negedge clk);
        por_evt = 1'b0; bor_evt = 1'b0; wdt_evt = 1'b0; wake_int = 1'b0; sleeping = 1'b0;
    endtask

    // Count edges until startup_done, and compare with the length expected from ticks.
    task automatic measure(input bit full, input string req);
        int  edges = 0;
        int  ticks = 0;
        int  tedge = 0;
        int  exp;
        bit  seen = 0;
        bit  xt = (cfg_osc_mode < 3'd3);
        bit  pu = full && !cfg_pu_n;
        while (!seen && edges < 600) begin
            @(posedge clk);
            edges++;
            if (pu && ticks < P && slow_tick) begin
                ticks++;
                if (ticks == P) tedge = edges;
            end
            @(negedge clk);
            if (startup_done) seen = 1;
        end
        exp = (pu ? tedge : 0) + (xt ? O : C);
        check(seen && edges == exp, req, edges, exp);
    endtask

    // Bound on the whole run; reported as a failed check.
    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        string rq;
        // R1: reset state
        cycles(4);
        rst_n = 1'b1;
        check(core_rst == 1'b1 && startup_done == 1'b0, "R1 core",
              {core_rst, startup_done}, 2);
        check({flag_to, flag_pd, flag_pon} == 3'b110, "R1 flags",
              {flag_to, flag_pd, flag_pon}, 6);
        measure(1'b1, "R2 after reset");

        // Full chain sweep over event, mode and delay enable (R2, R3, R4, R5).
        for (int k = K_POR; k <= K_BOR; k++) begin
            for (int m = 0; m < 8; m++) begin
                for (int pn = 0; pn < 2; pn++) begin
                    @(negedge clk);
                    cfg_osc_mode = 3'(m);
                    cfg_pu_n = pn[0];
                    sw_set_pon = 1'b1;
                    @(posedge clk);
                    @(negedge clk);
                    sw_set_pon = 1'b0;
                    fire(k);
                    if (k == K_POR) begin
                        check({flag_to, flag_pd, flag_pon} == 3'b110, "R11 por flags",
                              {flag_to, flag_pd, flag_pon}, 6);
                    end else begin
                        check({flag_to, flag_pd, flag_pon, flag_bor} == 4'b1110, "R5 bor flags",
                              {flag_to, flag_pd, flag_pon, flag_bor}, 14);
                    end
                    if (k == K_BOR)      rq = "R5 length";
                    else if (m >= 3)     rq = "R4 length";
                    else if (pn == 0)    rq = "R2 length";
                    else                 rq = "R3 length";
                    measure(1'b1, rq);
                end
            end
        end

        // Short path sweep (R6, R7).
        for (int k = K_WDT_RUN; k <= K_INT; k++) begin
            for (int m = 0; m < 8; m++) begin
                int expf;
                @(negedge clk);
                cfg_osc_mode = 3'(m);
                cfg_pu_n = 1'b0;
                fire(k);
                expf = (k == K_WDT_RUN) ? 1 : (k == K_WDT_SLP) ? 0 : 2;
                check({flag_to, flag_pd} == 2'(expf), "R7 cause flags",
                      {flag_to, flag_pd}, expf);
                measure(1'b0, "R6 length");
            end
        end

        // R6: interrupt without sleep is ignored.
        cycles(1);
        wake_int = 1'b1;
        cycles(1);
        wake_int = 1'b0;
        cycles(2);
        check(startup_done == 1'b1 && {flag_to, flag_pd} == 2'b10, "R6 ignore",
              {startup_done, flag_to, flag_pd}, 6);

        // R11: software set, then kept across brown-out and watchdog.
        cfg_osc_mode = 3'd4;
        cfg_pu_n = 1'b1;
        sw_set_pon = 1'b1;
        sw_set_bor = 1'b1;
        cycles(1);
        sw_set_pon = 1'b0;
        sw_set_bor = 1'b0;
        check(flag_pon == 1'b1 && flag_bor == 1'b1, "R11 sw set", {flag_pon, flag_bor}, 3);
        fire(K_BOR);
        measure(1'b1, "R5 length rc");
        fire(K_WDT_RUN);
        check(flag_pon == 1'b1 && flag_bor == 1'b0, "R11 kept", {flag_pon, flag_bor}, 2);
        measure(1'b0, "R6 length rc");

        // R12: restart during a running sequence.
        cfg_osc_mode = 3'd0;
        cfg_pu_n = 1'b0;
        fire(K_POR);
        cycles(8);
        check(startup_done == 1'b0, "R12 busy", startup_done, 0);
        fire(K_BOR);
        measure(1'b1, "R12 restart length");

        // R13: simultaneous events.
        @(negedge clk);
        sw_set_pon = 1'b1;
        sw_set_bor = 1'b1;
        cycles(1);
        sw_set_pon = 1'b0;
        sw_set_bor = 1'b0;
        por_evt = 1'b1;
        bor_evt = 1'b1;
        wdt_evt = 1'b1;
        cycles(1);
        por_evt = 1'b0;
        bor_evt = 1'b0;
        wdt_evt = 1'b0;
        check({flag_to, flag_pd, flag_pon, flag_bor} == 4'b1101, "R13 por wins",
              {flag_to, flag_pd, flag_pon, flag_bor}, 13);
        bor_evt = 1'b1;
        wdt_evt = 1'b1;
        cycles(1);
        bor_evt = 1'b0;
        wdt_evt = 1'b0;
        check({flag_to, flag_pd, flag_pon, flag_bor} == 4'b1100, "R13 bor wins",
              {flag_to, flag_pd, flag_pon, flag_bor}, 12);
        measure(1'b1, "R13 length");

        // R8: pin during run keeps the flags and holds the core.
        fire(K_WDT_RUN);
        measure(1'b0, "R6 length pre-pin");
        ext_rst_n = 1'b0;
        cycles(3);
        check(core_rst == 1'b1 && startup_done == 1'b1, "R8 hold",
              {core_rst, startup_done}, 3);
        check({flag_to, flag_pd} == 2'b01, "R8 flags", {flag_to, flag_pd}, 1);
        ext_rst_n = 1'b1;
        cycles(2);
        check(core_rst == 1'b0, "R8 release", core_rst, 0);

        // R9: pin during sleep.
        sleeping = 1'b1;
        ext_rst_n = 1'b0;
        cycles(3);
        check({flag_to, flag_pd} == 2'b10, "R9 flags", {flag_to, flag_pd}, 2);
        ext_rst_n = 1'b1;
        sleeping = 1'b0;
        cycles(2);

        // R10: pin still low after all delays, then released.
        ext_rst_n = 1'b0;
        cycles(3);
        cfg_osc_mode = 3'd3;
        cfg_pu_n = 1'b1;
        fire(K_POR);
        measure(1'b1, "R10 length");
        check(core_rst == 1'b1, "R10 held after delays", core_rst, 1);
        ext_rst_n = 1'b1;
        cycles(1);
        check(core_rst == 1'b1, "R10 one edge", core_rst, 1);
        cycles(1);
        check(core_rst == 1'b0, "R10 two edges", core_rst, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule